// File: doc/BRIEF.md
# Read-to-Write Turnaround Scheduler

This block sits between a single requester and a burst memory port that shares one data bus for both directions. Read and write requests come in over a valid/ready handshake. Each accepted request is driven out one cycle later as a registered read or write command strobe, together with a burst-aligned address. Every command moves a burst of four words.

The shared bus needs dead time when it turns from reading to writing. The scheduler therefore keeps a minimum number of no-operation cycles between a read command and the write that follows it. That minimum is one cycle in the normal frequency mode and two in the high-frequency mode, which a configuration input selects. Turning from a write to a read costs nothing, and runs of commands in the same direction go out on consecutive cycles. Idle cycles that have already passed since the last read count toward the required gap.

Top module: `rw_turn_sched`

## Requirements
- R1: After reset both command strobes are low and, with no request pending, `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) appears on the very next cycle as exactly one strobe: `cmd_wr` when `req_write` is 1, `cmd_rd` when it is 0. `cmd_addr` equals `req_addr` with its two least significant bits cleared (a four-word burst boundary).
- R3: In a cycle that follows an edge with no accepted request, both `cmd_rd` and `cmd_wr` are low (no-operation).
- R4: With `hi_freq` = 0, a write that follows a read is issued with exactly one no-operation cycle between them when the requester presents it immediately.
- R5: With `hi_freq` = 1, a write that follows a read is issued with exactly two no-operation cycles between them when the requester presents it immediately.
- R6: A read that follows a write is issued on the next cycle, with no gap.
- R7: Back-to-back reads, and back-to-back writes, are issued on consecutive cycles.
- R8: While a write waits out the turnaround, `req_ready` is low and both strobes stay low.
- R9: No-operation cycles already elapsed since the last read count toward the gap. The write waits only for the cycles still missing, and not at all once the gap is covered.
- R10: `hi_freq` is captured only in cycles with no turnaround in progress. A change during a turnaround does not alter the length of that turnaround.
- R11: The tracked previous direction resets to "write", so the first command after reset, read or write, is accepted without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hi_freq | input | 1 | 1 selects a two-cycle read-to-write gap, 0 selects one cycle |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | ADDR_W | Request word address |
| req_ready | output | 1 | Request accepted on this edge when high together with `req_valid` |
| cmd_rd | output | 1 | Read command strobe |
| cmd_wr | output | 1 | Write command strobe |
| cmd_addr | output | ADDR_W | Burst-aligned command address |

## Verification
On every cycle, the assertions check four things: the strobes are exclusive, an accepted request becomes a command and a refused one a no-operation, a write never directly follows a read, and in high-frequency mode no read appears in the two cycles before a write. They also check that a write-to-read or read-to-read step is never refused and that the captured mode holds still through a turnaround. Some properties are visible only from the bench's sweeps over both modes, all direction pairs and zero to three pre-elapsed idle cycles: the exact number of stall cycles, that a gap is only as long as needed, the address alignment, that a mode change mid-turnaround has no effect, and reset behaviour.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } rts_cmd_e;

endpackage

// File: rtl/rts_gap_track.sv
module rts_gap_track #(
  parameter int GAP_LO = 1,
  parameter int GAP_HI = 2,
  localparam int CNT_W = (GAP_HI < 1) ? 1 : $clog2(GAP_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_freq_in,
  input  logic pend_wr,
  input  logic acc,
  input  logic acc_wr,
  output logic turn,
  output logic hi_q
);

  localparam logic [CNT_W-1:0] NEED_LO = CNT_W'(GAP_LO);
  localparam logic [CNT_W-1:0] NEED_HI = CNT_W'(GAP_HI);

  logic             last_rd_q, last_rd_d;
  logic [CNT_W-1:0] idle_q, idle_d;
  logic             hi_d;
  logic [CNT_W-1:0] need;

  always_comb begin
    need = hi_q ? NEED_HI : NEED_LO;
    turn = pend_wr && last_rd_q && (idle_q < need);
  end

  always_comb begin
    last_rd_d = last_rd_q;
    idle_d    = idle_q;
    if (acc) begin
      last_rd_d = !acc_wr;
      idle_d    = '0;
    end else if (idle_q != NEED_HI) begin
      idle_d = idle_q + 1'b1;
    end
    hi_d = turn ? hi_q : hi_freq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd_q <= 1'b0;
      idle_q    <= NEED_HI;
      hi_q      <= 1'b0;
    end else begin
      last_rd_q <= last_rd_d;
      idle_q    <= idle_d;
      hi_q      <= hi_d;
    end
  end

  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (turn && $past(turn)) |-> $stable(hi_q))
    else $error("R10: mode changed during turnaround");

endmodule

// File: rtl/rts_cmd_reg.sv
module rts_cmd_reg
  import rts_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BURST_LEN = 4,
  localparam int OFF_W    = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);

  localparam logic [ADDR_W-1:0] ALIGN = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  rts_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = addr_q;
    if (load) begin
      cmd_d  = wr ? CMD_WR : CMD_RD;
      addr_d = addr & ALIGN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      if (load) addr_q <= addr_d;
    end
  end

  assign cmd_rd   = (cmd_q == CMD_RD);
  assign cmd_wr   = (cmd_q == CMD_WR);
  assign cmd_addr = addr_q;

endmodule

// File: rtl/rw_turn_sched.sv
module rw_turn_sched #(
  parameter int ADDR_W    = 12,
  parameter int BURST_LEN = 4,
  parameter int GAP_LO    = 1,
  parameter int GAP_HI    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_freq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);

  logic turn;
  logic hi_q;
  logic acc;

  rts_gap_track #(
    .GAP_LO (GAP_LO),
    .GAP_HI (GAP_HI)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_freq_in (hi_freq),
    .pend_wr    (req_valid && req_write),
    .acc        (acc),
    .acc_wr     (req_write),
    .turn       (turn),
    .hi_q       (hi_q)
  );

  assign req_ready = !turn;
  assign acc       = req_valid && req_ready;

  rts_cmd_reg #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc),
    .wr       (req_write),
    .addr     (req_addr),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_addr (cmd_addr)
  );

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_rd && cmd_wr))
    else $error("R2: both strobes high");

  a_r2_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_rd || cmd_wr))
    else $error("R2: accepted request not issued");

  a_r3_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!cmd_rd && !cmd_wr))
    else $error("R3: command without acceptance");

  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !$past(cmd_rd))
    else $error("R4: write directly after read");

  a_r5_hi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && $past(hi_q)) |-> (!$past(cmd_rd) && !$past(cmd_rd, 2)))
    else $error("R5: high-frequency gap too short");

  a_r6_wr_to_rd_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && req_valid && !req_write) |-> req_ready)
    else $error("R6: read stalled after write");

  a_r7_rd_to_rd_free: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && req_valid && !req_write) |-> req_ready)
    else $error("R7: read stalled after read");

endmodule

// File: tb/rw_turn_sched_test.sv
module rw_turn_sched_test;

  localparam int AW = 12;

  logic          clk;
  logic          rst_n;
  logic          hi_freq;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic          cmd_rd;
  logic          cmd_wr;
  logic [AW-1:0] cmd_addr;

  int n_tests;
  int n_fail;
  int cyc;

  rw_turn_sched #(.ADDR_W(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi_freq   (hi_freq),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_addr  (cmd_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Waits n cycles with no request; every one of them must be a no-operation.
  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!cmd_rd && !cmd_wr, "R3 nop when idle", {cmd_rd, cmd_wr}, 0);
    end
  endtask

  // Presents one request, counts stall cycles, checks the issued command.
  task automatic do_req(input bit w, input logic [AW-1:0] a, input bit chg,
                        input bit new_mode, output int stalls);
    stalls    = 0;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    #1;
    while (!req_ready && stalls < 10) begin
      if (chg && stalls == 0) hi_freq = new_mode;
      @(negedge clk);
      stalls = stalls + 1;
      chk(!cmd_rd && !cmd_wr, "R8 nop during turnaround", {cmd_rd, cmd_wr}, 0);
      #1;
    end
    @(negedge clk);
    chk(cmd_wr == w && cmd_rd == !w, "R2 strobe", {cmd_rd, cmd_wr}, {!w, w});
    chk(cmd_addr == (a & ~AW'(3)), "R2 aligned address", cmd_addr, a & ~AW'(3));
  endtask

  initial begin
    int st;
    int exp_st;
    n_tests = 0;
    n_fail  = 0;
    cyc     = 0;
    hi_freq = 1'b0;
    apply_reset();

    // R1: reset state
    chk(!cmd_rd && !cmd_wr, "R1 strobes after reset", {cmd_rd, cmd_wr}, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // R11: first read after reset, then first write after a fresh reset
    do_req(1'b0, 12'h123, 1'b0, 1'b0, st);
    chk(st == 0, "R11 first read no gap", st, 0);
    apply_reset();
    do_req(1'b1, 12'h0ff, 1'b0, 1'b0, st);
    chk(st == 0, "R11 first write no gap", st, 0);
    idle(2);

    // Sweep: mode x direction pair x pre-elapsed idle cycles (R4 R5 R6 R7 R9)
    for (int m = 0; m < 2; m++) begin
      hi_freq = m[0];
      idle(2);
      for (int p = 0; p < 4; p++) begin
        for (int pre = 0; pre < 4; pre++) begin
          bit w1;
          bit w2;
          w1 = p[1];
          w2 = p[0];
          do_req(w1, AW'(p * 37 + pre * 5 + m), 1'b0, 1'b0, st);
          if (pre > 0) idle(pre);
          do_req(w2, AW'(p * 91 + pre * 13 + 2 + m), 1'b0, 1'b0, st);
          if (!w1 && w2) begin
            exp_st = (m + 1) - pre;
            if (exp_st < 0) exp_st = 0;
            if (pre == 0 && m == 0)
              chk(st == exp_st, "R4 one nop read->write", st, exp_st);
            else if (pre == 0)
              chk(st == exp_st, "R5 two nops read->write", st, exp_st);
            else
              chk(st == exp_st, "R9 elapsed idle counts", st, exp_st);
          end else if (w1 && !w2) begin
            chk(st == 0, "R6 write->read free", st, 0);
          end else begin
            chk(st == 0, "R7 same direction free", st, 0);
          end
          idle(3);
        end
      end
    end

    // R7: a longer run of reads then writes, consecutive
    hi_freq = 1'b1;
    idle(2);
    for (int i = 0; i < 3; i++) begin
      do_req(1'b0, AW'(i * 4), 1'b0, 1'b0, st);
      chk(st == 0, "R7 read run", st, 0);
    end
    do_req(1'b1, AW'(100), 1'b0, 1'b0, st);
    chk(st == 2, "R5 after read run", st, 2);
    for (int i = 0; i < 3; i++) begin
      do_req(1'b1, AW'(200 + i), 1'b0, 1'b0, st);
      chk(st == 0, "R7 write run", st, 0);
    end
    idle(3);

    // R10: mode flips during a turnaround do not change its length
    hi_freq = 1'b0;
    idle(2);
    do_req(1'b0, AW'(8), 1'b0, 1'b0, st);
    do_req(1'b1, AW'(12), 1'b1, 1'b1, st);
    chk(st == 1, "R10 lo->hi mid-turnaround", st, 1);
    idle(3);
    hi_freq = 1'b1;
    idle(2);
    do_req(1'b0, AW'(16), 1'b0, 1'b0, st);
    do_req(1'b1, AW'(20), 1'b1, 1'b0, st);
    chk(st == 2, "R10 hi->lo mid-turnaround", st, 2);
    idle(3);
    // new mode (lo) now in effect
    do_req(1'b0, AW'(24), 1'b0, 1'b0, st);
    do_req(1'b1, AW'(28), 1'b0, 1'b0, st);
    chk(st == 1, "R10 new mode applies after", st, 1);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule